// File: doc/BRIEF.md
# Configuration Item DMA Engine

This block moves configuration items into system memory without the host having to pull them out one byte at a time. The host publishes a small descriptor in memory and then rings a doorbell by writing the descriptor's 64-bit bus address. The engine reads the descriptor, optionally points the item store at a new item, and then either copies item bytes to a target buffer or discards them. When the item runs out before the requested length is satisfied, the buffer is padded with zero bytes. Finally, a status word is written back over the descriptor's control field, so the host can poll memory for completion.

The doorbell sits in a small register window. Reading that window returns a fixed 8-byte identification pattern, which software uses to probe for the engine. On the memory side, the engine is a byte-wide master with one request outstanding at a time. On the item side, it drives a select strobe with a 16-bit key, reads a current-byte / bytes-remaining pair, and drives an advance strobe that steps the store's read offset.

Top module: `cfg_dma_engine`

## Requirements
- R1: Writing a 4-byte value at window offset 0 loads the upper 32 address bits and clears the lower ones. A 4-byte write at offset 4 then ORs in the lower 32 bits and starts a transfer from the combined address. A single 8-byte write at offset 0 loads the full address and starts a transfer.
- R2: Starting a transfer resets the latched doorbell address to zero. A lone 4-byte write at offset 4 that follows a completed transfer therefore fetches from an address whose upper 32 bits are zero.
- R3: A read of size 1, 2, 4 or 8 bytes at offset `o` returns the identification value 0x51454D5520434647 shifted right by 8*(8-o-size) bits and masked to `size` bytes. The result appears on `db_rdata` one clock after the read strobe. Any read that would run past byte 8, or uses another size, returns zero.
- R4: The descriptor is 16 bytes and is fetched byte by byte in ascending address order. It holds three big-endian fields: the control word at bytes 0..3, the length at bytes 4..7 and the target address at bytes 8..15.
- R5: When control bit 3 is set, the engine pulses `itm_sel` for one cycle with `itm_key` equal to control bits 31..16. This happens before any item byte is consumed.
- R6: When control bit 1 is set, the engine writes `length` bytes to ascending target addresses. While the item store reports a byte available, that byte is written and the store is advanced. Once no byte is available, or no valid item is selected, zero bytes are written instead.
- R7: When control bit 2 is set and bit 1 is clear, the store's offset advances by up to `length` bytes and no data writes are made. A later read without a select resumes from the advanced offset.
- R8: When neither bit 1 nor bit 2 is set, the length is treated as zero. No data bytes are written, and the status written back is zero.
- R9: An error response to a data write sets the status error bit (bit 0). No further data writes are issued after that response, and the rejected byte is not stored.
- R10: An error response during the descriptor fetch aborts the fetch. No select and no data movement happen, and the control field is overwritten with the status value 1.
- R11: At the end of every transfer, the engine writes the 32-bit status word big-endian to descriptor bytes 0..3. Bits 31..1 are zero and bit 0 is the error flag.
- R12: `busy` is low after reset. It rises in the cycle after the starting doorbell write and falls after the last status byte is accepted. Doorbell writes made while `busy` is high are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| db_wr | input | 1 | Doorbell window write strobe |
| db_rd | input | 1 | Doorbell window read strobe |
| db_off | input | 3 | Byte offset of the access within the window |
| db_size | input | 4 | Access size in bytes (1, 2, 4 or 8) |
| db_wdata | input | 64 | Write value, right-aligned |
| db_rdata | output | 64 | Registered read value, right-aligned |
| busy | output | 1 | Transfer in progress |
| mem_req | output | 1 | Memory request, held until `mem_rsp` |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Byte address of the request |
| mem_wdata | output | 8 | Write byte |
| mem_rsp | input | 1 | One-cycle response to the pending request |
| mem_rdata | input | 8 | Read byte, valid with `mem_rsp` |
| mem_err | input | 1 | Error flag, valid with `mem_rsp` |
| itm_sel | output | 1 | One-cycle item select pulse |
| itm_key | output | 16 | Item key for the select |
| itm_avail | input | 1 | The store has a byte at its current offset |
| itm_byte | input | 8 | Byte at the store's current offset |
| itm_adv | output | 1 | Advance the store offset by one |

## Verification
Two functions of the engine can fall in the same cycle. The first is the doorbell decode, which sees a host write. The second is the sequencer, which is busy fetching a descriptor or writing status back. The bench provokes the overlap by ringing the doorbell again one cycle after a transfer starts, with a different descriptor address, and by reading the identification value in that same busy window. It judges the result through the monitored memory traffic: exactly one 16-byte fetch, all from the first address, then `busy` low with no further requests. The identification read must still return its correct slice during the transfer.

// File: rtl/cfg_dma_pkg.sv
package cfg_dma_pkg;

  // identification pattern returned by the doorbell window
  localparam logic [63:0] ID_PATTERN = 64'h5145_4D55_2043_4647;

  // descriptor layout (bytes)
  localparam int DESC_BYTES   = 16;
  localparam int STATUS_BYTES = 4;

  // control word flag positions
  localparam int FLAG_ERR  = 0;
  localparam int FLAG_READ = 1;
  localparam int FLAG_SKIP = 2;
  localparam int FLAG_SEL  = 3;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_FETCH,
    SQ_DECODE,
    SQ_SELWAIT,
    SQ_COPY,
    SQ_WBACK
  } seq_state_t;

endpackage

// File: rtl/cfg_dma_doorbell.sv
module cfg_dma_doorbell
  import cfg_dma_pkg::*;
#(
  parameter int ADDR_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic              rd,
  input  logic [2:0]        off,
  input  logic [3:0]        size,
  input  logic [63:0]       wdata,
  input  logic              busy,
  output logic [63:0]       rdata,
  output logic              start,
  output logic [ADDR_W-1:0] start_addr
);

  logic              wr_ok;
  logic              hi_w;
  logic              lo_w;
  logic              full_w;
  logic [ADDR_W-1:0] addr_q;

  assign wr_ok  = wr && !busy;
  assign hi_w   = wr_ok && (size == 4'd4) && (off == 3'd0);
  assign lo_w   = wr_ok && (size == 4'd4) && (off == 3'd4);
  assign full_w = wr_ok && (size == 4'd8) && (off == 3'd0);
  assign start  = lo_w || full_w;

  assign start_addr = full_w ? ADDR_W'(wdata)
                             : (addr_q | ADDR_W'({32'h0, wdata[31:0]}));

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
    end else if (hi_w) begin
      addr_q <= ADDR_W'({wdata[31:0], 32'h0});
    end else if (start) begin
      addr_q <= '0;
    end
  end

  // identification read: slice by offset and size, big-endian
  logic [4:0]  end_b;
  logic [3:0]  gap;
  logic        legal;
  logic [63:0] sliced;
  logic [63:0] mask;
  logic [63:0] rd_val;

  always_comb begin
    end_b  = 5'(off) + 5'(size);
    legal  = (end_b <= 5'd8) &&
             ((size == 4'd1) || (size == 4'd2) || (size == 4'd4) || (size == 4'd8));
    gap    = 4'(5'd8 - end_b);
    sliced = ID_PATTERN >> {gap, 3'b000};
    mask   = (size == 4'd8) ? {64{1'b1}} : ~({64{1'b1}} << {size, 3'b000});
    rd_val = legal ? (sliced & mask) : 64'h0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd) begin
      rdata <= rd_val;
    end
  end

endmodule

// File: rtl/cfg_dma_seq.sv
module cfg_dma_seq
  import cfg_dma_pkg::*;
#(
  parameter int ADDR_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  output logic              busy,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  input  logic              mem_rsp,
  input  logic [7:0]        mem_rdata,
  input  logic              mem_err,
  output logic              itm_sel,
  output logic [15:0]       itm_key,
  input  logic              itm_avail,
  input  logic [7:0]        itm_byte,
  output logic              itm_adv
);

  localparam int BUF_W   = DESC_BYTES * 8;
  localparam int IDX_W   = $clog2(DESC_BYTES);
  localparam logic [IDX_W-1:0] IDX_LAST_D = IDX_W'(DESC_BYTES - 1);
  localparam logic [IDX_W-1:0] IDX_LAST_S = IDX_W'(STATUS_BYTES - 1);

  seq_state_t        state_q;
  logic [ADDR_W-1:0] desc_q;
  logic [BUF_W-1:0]  buf_q;
  logic [IDX_W-1:0]  idx_q;
  logic [31:0]       len_q;
  logic [ADDR_W-1:0] tgt_q;
  logic              rd_mode_q;
  logic              err_q;

  logic [31:0] ctl_w;
  logic        unused_ctl_bits;

  assign ctl_w           = buf_q[BUF_W-1 -: 32];
  assign unused_ctl_bits = ^{ctl_w[15:4], ctl_w[FLAG_ERR]};

  // advance the store whenever a byte is consumed (issued write or skip)
  assign itm_adv = (state_q == SQ_COPY) && !mem_req && (len_q != 32'd0) &&
                   !err_q && itm_avail;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= SQ_IDLE;
      desc_q    <= '0;
      buf_q     <= '0;
      idx_q     <= '0;
      len_q     <= '0;
      tgt_q     <= '0;
      rd_mode_q <= 1'b0;
      err_q     <= 1'b0;
      busy      <= 1'b0;
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      itm_sel   <= 1'b0;
      itm_key   <= '0;
    end else begin
      unique case (state_q)
        SQ_IDLE: begin
          if (start) begin
            desc_q  <= start_addr;
            idx_q   <= '0;
            err_q   <= 1'b0;
            busy    <= 1'b1;
            state_q <= SQ_FETCH;
          end
        end

        SQ_FETCH: begin
          if (!mem_req) begin
            mem_req  <= 1'b1;
            mem_we   <= 1'b0;
            mem_addr <= desc_q + ADDR_W'(idx_q);
          end else if (mem_rsp) begin
            mem_req <= 1'b0;
            if (mem_err) begin
              err_q   <= 1'b1;
              idx_q   <= '0;
              state_q <= SQ_WBACK;
            end else begin
              buf_q <= {buf_q[BUF_W-9:0], mem_rdata};
              if (idx_q == IDX_LAST_D) begin
                state_q <= SQ_DECODE;
              end else begin
                idx_q <= idx_q + 1'b1;
              end
            end
          end
        end

        SQ_DECODE: begin
          err_q     <= 1'b0;
          idx_q     <= '0;
          tgt_q     <= ADDR_W'(buf_q[63:0]);
          rd_mode_q <= ctl_w[FLAG_READ];
          len_q     <= (ctl_w[FLAG_READ] || ctl_w[FLAG_SKIP]) ? buf_q[95:64] : 32'd0;
          if (ctl_w[FLAG_SEL]) begin
            itm_sel <= 1'b1;
            itm_key <= ctl_w[31:16];
            state_q <= SQ_SELWAIT;
          end else begin
            state_q <= SQ_COPY;
          end
        end

        SQ_SELWAIT: begin
          itm_sel <= 1'b0;
          state_q <= SQ_COPY;
        end

        SQ_COPY: begin
          if (mem_req) begin
            if (mem_rsp) begin
              mem_req <= 1'b0;
              err_q   <= err_q | mem_err;
              len_q   <= len_q - 32'd1;
              tgt_q   <= tgt_q + 1'b1;
            end
          end else if ((len_q == 32'd0) || err_q) begin
            idx_q   <= '0;
            state_q <= SQ_WBACK;
          end else if (rd_mode_q) begin
            mem_req   <= 1'b1;
            mem_we    <= 1'b1;
            mem_addr  <= tgt_q;
            mem_wdata <= itm_avail ? itm_byte : 8'h00;
          end else begin
            len_q <= len_q - 32'd1;
            tgt_q <= tgt_q + 1'b1;
          end
        end

        SQ_WBACK: begin
          if (!mem_req) begin
            mem_req   <= 1'b1;
            mem_we    <= 1'b1;
            mem_addr  <= desc_q + ADDR_W'(idx_q);
            mem_wdata <= (idx_q == IDX_LAST_S) ? {7'b0, err_q} : 8'h00;
          end else if (mem_rsp) begin
            mem_req <= 1'b0;
            if (idx_q == IDX_LAST_S) begin
              mem_we  <= 1'b0;
              busy    <= 1'b0;
              state_q <= SQ_IDLE;
            end else begin
              idx_q <= idx_q + 1'b1;
            end
          end
        end

        default: state_q <= SQ_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/cfg_dma_engine.sv
module cfg_dma_engine #(
  parameter int ADDR_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              db_wr,
  input  logic              db_rd,
  input  logic [2:0]        db_off,
  input  logic [3:0]        db_size,
  input  logic [63:0]       db_wdata,
  output logic [63:0]       db_rdata,
  output logic              busy,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  input  logic              mem_rsp,
  input  logic [7:0]        mem_rdata,
  input  logic              mem_err,
  output logic              itm_sel,
  output logic [15:0]       itm_key,
  input  logic              itm_avail,
  input  logic [7:0]        itm_byte,
  output logic              itm_adv
);

  logic              kick;
  logic [ADDR_W-1:0] kick_addr;

  cfg_dma_doorbell #(.ADDR_W(ADDR_W)) u_bell (
    .clk        (clk),
    .rst        (rst),
    .wr         (db_wr),
    .rd         (db_rd),
    .off        (db_off),
    .size       (db_size),
    .wdata      (db_wdata),
    .busy       (busy),
    .rdata      (db_rdata),
    .start      (kick),
    .start_addr (kick_addr)
  );

  cfg_dma_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .start      (kick),
    .start_addr (kick_addr),
    .busy       (busy),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .mem_rsp    (mem_rsp),
    .mem_rdata  (mem_rdata),
    .mem_err    (mem_err),
    .itm_sel    (itm_sel),
    .itm_key    (itm_key),
    .itm_avail  (itm_avail),
    .itm_byte   (itm_byte),
    .itm_adv    (itm_adv)
  );

endmodule

// File: rtl/cfg_dma_engine_chk.sv
module cfg_dma_engine_chk #(
  parameter int ADDR_W = 64
) (
  input logic              clk,
  input logic              rst,
  input logic              db_wr,
  input logic              db_rd,
  input logic [2:0]        db_off,
  input logic [3:0]        db_size,
  input logic [63:0]       db_rdata,
  input logic              busy,
  input logic              mem_req,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [7:0]        mem_wdata,
  input logic              mem_rsp,
  input logic              itm_sel,
  input logic              itm_adv
);

  AST_START_LO: assert property (@(posedge clk) disable iff (rst)
    (db_wr && !busy && db_off == 3'd4 && db_size == 4'd4) |=> busy); // R1

  AST_ID_FULL: assert property (@(posedge clk) disable iff (rst)
    (db_rd && db_off == 3'd0 && db_size == 4'd8) |=> (db_rdata == 64'h5145_4D55_2043_4647)); // R3

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_rsp) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata))); // R6

  AST_SEL_ONE: assert property (@(posedge clk) disable iff (rst)
    itm_sel |=> !itm_sel); // R5

  AST_SEL_QUIET: assert property (@(posedge clk) disable iff (rst)
    itm_sel |-> (busy && !mem_req && !itm_adv)); // R5

  AST_ADV_BUSY: assert property (@(posedge clk) disable iff (rst)
    itm_adv |-> (busy && !mem_req)); // R7

  AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mem_req); // R12

endmodule

bind cfg_dma_engine cfg_dma_engine_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .db_wr     (db_wr),
  .db_rd     (db_rd),
  .db_off    (db_off),
  .db_size   (db_size),
  .db_rdata  (db_rdata),
  .busy      (busy),
  .mem_req   (mem_req),
  .mem_we    (mem_we),
  .mem_addr  (mem_addr),
  .mem_wdata (mem_wdata),
  .mem_rsp   (mem_rsp),
  .itm_sel   (itm_sel),
  .itm_adv   (itm_adv)
);

// File: tb/cfg_dma_engine_tb_top.sv
module cfg_dma_engine_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        db_wr = 1'b0;
  logic        db_rd = 1'b0;
  logic [2:0]  db_off = '0;
  logic [3:0]  db_size = '0;
  logic [63:0] db_wdata = '0;
  logic [63:0] db_rdata;
  logic        busy;
  logic        mem_req, mem_we;
  logic [63:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic        mem_rsp;
  logic [7:0]  mem_rdata;
  logic        mem_err;
  logic        itm_sel;
  logic [15:0] itm_key;
  logic        itm_avail;
  logic [7:0]  itm_byte;
  logic        itm_adv;

  int n_chk = 0;
  int n_err = 0;

  always #10 clk = ~clk; // 50 MHz

  cfg_dma_engine dut_i (
    .clk(clk), .rst(rst), .db_wr(db_wr), .db_rd(db_rd), .db_off(db_off),
    .db_size(db_size), .db_wdata(db_wdata), .db_rdata(db_rdata), .busy(busy),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rsp(mem_rsp), .mem_rdata(mem_rdata), .mem_err(mem_err),
    .itm_sel(itm_sel), .itm_key(itm_key), .itm_avail(itm_avail),
    .itm_byte(itm_byte), .itm_adv(itm_adv)
  );

  // ---------------- memory model ----------------
  logic [7:0] mem [0:1023];
  logic       err_en = 1'b0;
  logic [9:0] err_at = '0;

  always @(posedge clk) begin
    if (rst) begin
      mem_rsp   <= 1'b0;
      mem_err   <= 1'b0;
      mem_rdata <= '0;
    end else if (mem_req && !mem_rsp) begin
      mem_rsp   <= 1'b1;
      mem_err   <= err_en && (mem_addr[9:0] == err_at);
      mem_rdata <= mem[mem_addr[9:0]];
      if (mem_we && !(err_en && (mem_addr[9:0] == err_at)))
        mem[mem_addr[9:0]] <= mem_wdata;
    end else begin
      mem_rsp <= 1'b0;
      mem_err <= 1'b0;
    end
  end

  // ---------------- item store model ----------------
  // key 5: 6 bytes A0+i ; key 7: 3 bytes B0+i ; other keys invalid
  logic [15:0] st_key;
  logic [7:0]  st_off;

  always @(posedge clk) begin
    if (rst) begin
      st_key <= 16'hFFFF;
      st_off <= '0;
    end else if (itm_sel) begin
      st_key <= itm_key;
      st_off <= '0;
    end else if (itm_adv) begin
      st_off <= st_off + 8'd1;
    end
  end

  assign itm_avail = ((st_key == 16'd5) && (st_off < 8'd6)) ||
                     ((st_key == 16'd7) && (st_off < 8'd3));
  assign itm_byte  = ((st_key == 16'd5) ? 8'hA0 : 8'hB0) + st_off;

  // ---------------- traffic monitor ----------------
  logic        mon_clr = 1'b0;
  int          wr_cnt, rd_cnt, sel_cnt;
  logic [15:0] sel_key;
  logic [63:0] first_addr;
  logic        seen_first;

  always @(posedge clk) begin
    if (mon_clr) begin
      wr_cnt <= 0; rd_cnt <= 0; sel_cnt <= 0; seen_first <= 1'b0;
      sel_key <= '0; first_addr <= '0;
    end else begin
      if (mem_rsp && mem_req && mem_we)  wr_cnt <= wr_cnt + 1;
      if (mem_rsp && mem_req && !mem_we) rd_cnt <= rd_cnt + 1;
      if (mem_req && !mem_we && !seen_first) begin
        first_addr <= mem_addr;
        seen_first <= 1'b1;
      end
      if (itm_sel) begin
        sel_cnt <= sel_cnt + 1;
        sel_key <= itm_key;
      end
    end
  end

  // ---------------- helpers ----------------
  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clear_mon();
    @(negedge clk) mon_clr = 1'b1;
    @(negedge clk) mon_clr = 1'b0;
  endtask

  task automatic bell(input logic [2:0] o, input logic [3:0] s, input logic [63:0] d);
    @(negedge clk);
    db_wr = 1'b1; db_off = o; db_size = s; db_wdata = d;
    @(negedge clk);
    db_wr = 1'b0;
  endtask

  task automatic id_read(input logic [2:0] o, input logic [3:0] s, output logic [63:0] v);
    @(negedge clk);
    db_rd = 1'b1; db_off = o; db_size = s;
    @(negedge clk);
    db_rd = 1'b0;
    v = db_rdata;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (busy) @(negedge clk);
  endtask

  task automatic put_desc(input logic [9:0] b, input logic [31:0] ctl,
                          input logic [31:0] len, input logic [63:0] tgt);
    for (int i = 0; i < 4; i++) mem[b + 10'(i)]     = ctl[31 - 8*i -: 8];
    for (int i = 0; i < 4; i++) mem[b + 10'(4 + i)] = len[31 - 8*i -: 8];
    for (int i = 0; i < 8; i++) mem[b + 10'(8 + i)] = tgt[63 - 8*i -: 8];
  endtask

  task automatic fill(input logic [9:0] b, input int n, input logic [7:0] v);
    for (int i = 0; i < n; i++) mem[b + 10'(i)] = v;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  // identification table: {offset, size, expected}
  localparam logic [70:0] ID_TAB [8] = '{
    {3'd0, 4'd8, 64'h5145_4D55_2043_4647},
    {3'd0, 4'd4, 64'h0000_0000_5145_4D55},
    {3'd4, 4'd4, 64'h0000_0000_2043_4647},
    {3'd0, 4'd1, 64'h0000_0000_0000_0051},
    {3'd7, 4'd1, 64'h0000_0000_0000_0047},
    {3'd2, 4'd2, 64'h0000_0000_0000_4D55},
    {3'd6, 4'd2, 64'h0000_0000_0000_4647},
    {3'd6, 4'd4, 64'h0}
  };

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [63:0] v;
    for (int i = 0; i < 1024; i++) mem[i] = 8'h00;
    mon_clr = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    mon_clr = 1'b0;
    @(negedge clk);

    // reset state (R12)
    check("R12 reset busy", 64'(busy), 64'd0);
    check("R12 reset mem_req", 64'(mem_req), 64'd0);
    check("R3 reset rdata", db_rdata, 64'd0);

    // identification table walk (R3)
    for (int i = 0; i < 8; i++) begin
      logic [70:0] e;
      e = ID_TAB[i];
      id_read(e[70:68], e[67:64], v);
      check("R3 id slice", v, e[63:0]);
    end

    // A: two-half doorbell, select key 5 + read 8 (zero fill past 6) (R1 R4 R5 R6 R11)
    put_desc(10'h100, 32'h0005_000A, 32'd8, 64'h200);
    fill(10'h200, 8, 8'hFF);
    clear_mon();
    bell(3'd0, 4'd4, 64'h1);
    bell(3'd4, 4'd4, 64'h100);
    wait_idle();
    check("R1 fetch addr from halves", first_addr, 64'h1_0000_0100);
    check("R4 descriptor fetch bytes", 64'(rd_cnt), 64'd16);
    check("R5 select count", 64'(sel_cnt), 64'd1);
    check("R5 select key", 64'(sel_key), 64'd5);
    for (int i = 0; i < 6; i++) check("R6 item byte", 64'(mem[10'h200 + 10'(i)]), 64'(8'hA0 + 8'(i)));
    check("R6 zero fill 6", 64'(mem[10'h206]), 64'd0);
    check("R6 zero fill 7", 64'(mem[10'h207]), 64'd0);
    check("R11 status b0", 64'(mem[10'h100]), 64'd0);
    check("R11 status b1", 64'(mem[10'h101]), 64'd0);
    check("R11 status b3", 64'(mem[10'h103]), 64'd0);

    // E: lone low half after a start, neither flag (R2 R8)
    put_desc(10'h180, 32'h0000_0010, 32'd5, 64'h300);
    mem[10'h300] = 8'h77;
    clear_mon();
    bell(3'd4, 4'd4, 64'h180);
    wait_idle();
    check("R2 latched address cleared", first_addr, 64'h180);
    check("R8 only status writes", 64'(wr_cnt), 64'd4);
    check("R8 target untouched", 64'(mem[10'h300]), 64'h77);
    check("R8 status zero", 64'(mem[10'h183]), 64'd0);

    // C: 8-byte doorbell, select key 7 + skip 2 (R1 R7)
    put_desc(10'h140, 32'h0007_000C, 32'd2, 64'h280);
    mem[10'h280] = 8'h55;
    clear_mon();
    bell(3'd0, 4'd8, 64'h140);
    wait_idle();
    check("R1 full-width doorbell", first_addr, 64'h140);
    check("R7 skip no data writes", 64'(wr_cnt), 64'd4);
    check("R7 skip target untouched", 64'(mem[10'h280]), 64'h55);
    check("R5 select key 7", 64'(sel_key), 64'd7);

    // D: read 3 without select, resumes at offset 2 of key 7 (R6 R7)
    put_desc(10'h2A0, 32'h0000_0002, 32'd3, 64'h2C0);
    fill(10'h2C0, 4, 8'hFF);
    clear_mon();
    bell(3'd0, 4'd8, 64'h2A0);
    wait_idle();
    check("R7 resumed offset byte", 64'(mem[10'h2C0]), 64'hB2);
    check("R6 past end zero a", 64'(mem[10'h2C1]), 64'h00);
    check("R6 past end zero b", 64'(mem[10'h2C2]), 64'h00);
    check("R6 length bound", 64'(mem[10'h2C3]), 64'hFF);
    check("R5 no select", 64'(sel_cnt), 64'd0);

    // fetch error (R10)
    put_desc(10'h1C0, 32'h0005_000A, 32'd4, 64'h240);
    fill(10'h240, 4, 8'h33);
    err_en = 1'b1; err_at = 10'h1C5;
    clear_mon();
    bell(3'd0, 4'd8, 64'h1C0);
    wait_idle();
    err_en = 1'b0;
    check("R10 fetch reads stop", 64'(rd_cnt), 64'd6);
    check("R10 no select", 64'(sel_cnt), 64'd0);
    check("R10 writes only status", 64'(wr_cnt), 64'd4);
    check("R10 target untouched", 64'(mem[10'h240]), 64'h33);
    check("R10 status word", {32'h0, mem[10'h1C0], mem[10'h1C1], mem[10'h1C2], mem[10'h1C3]}, 64'h1);

    // data write error (R9)
    put_desc(10'h1E0, 32'h0005_000A, 32'd6, 64'h340);
    fill(10'h340, 6, 8'hEE);
    err_en = 1'b1; err_at = 10'h342;
    clear_mon();
    bell(3'd0, 4'd8, 64'h1E0);
    wait_idle();
    err_en = 1'b0;
    check("R9 bytes before error", {48'h0, mem[10'h340], mem[10'h341]}, 64'hA0A1);
    check("R9 rejected byte not stored", 64'(mem[10'h342]), 64'hEE);
    check("R9 copy stopped", 64'(mem[10'h343]), 64'hEE);
    check("R9 write count", 64'(wr_cnt), 64'd7);
    check("R9 status error", {32'h0, mem[10'h1E0], mem[10'h1E1], mem[10'h1E2], mem[10'h1E3]}, 64'h1);

    // doorbell while busy, id read during transfer (R12 R3)
    put_desc(10'h3C0, 32'h0, 32'd0, 64'h0);
    put_desc(10'h380, 32'h0, 32'd0, 64'h0);
    clear_mon();
    bell(3'd0, 4'd8, 64'h3C0);
    check("R12 busy after start", 64'(busy), 64'd1);
    bell(3'd0, 4'd8, 64'h380);
    id_read(3'd4, 4'd4, v);
    check("R3 id read while busy", v, 64'h2043_4647);
    wait_idle();
    repeat (20) @(negedge clk);
    check("R12 single fetch", 64'(rd_cnt), 64'd16);
    check("R12 fetch from first address", first_addr, 64'h3C0);
    check("R12 idle after", 64'(busy), 64'd0);

    finish_run();
  end

endmodule